// File: doc/BRIEF.md
# Host Controller Interrupt Aggregator

This block combines six event sources of a USB host controller into a single interrupt request line. Each source has a sticky status bit and an enable bit. The bits for one source sit at the same position in a status register and in an enable register. Other parts of the controller report an event with a one-cycle pulse, and that pulse sets the matching status bit. Software acknowledges a source by writing 1 to the status bit.

The sources fall into two classes. The immediate class covers port change, frame list rollover and host system error. A source in this class drives the interrupt as soon as its status bit and its enable bit are both set. The deferred class covers transfer complete, USB error and async advance. A source in this class counts only after a threshold tick input samples it set and enabled. A pending-to-signal register then holds it until its status bit is cleared.

Both registers are reached through a simple word port with one write strobe, an address, write data and a combinational read-data path.

Top module: `hc_irq_aggregator`

## Requirements
- R1: After reset the status bits, the enable bits, the pending-to-signal register and the `irq` output are all 0.
- R2: Address 1 selects the enable register. Bits 5..0 are read/write. Bits 31..6 always read 0, whatever value is written to them.
- R3: Address 0 selects the status register. A one-cycle pulse on `evt_pulse[i]` sets status bit i at the next clock edge. Bits 31..6 of the status register read 0. The bit positions are: 0 transfer complete, 1 USB error, 2 port change, 3 frame list rollover, 4 host system error, 5 async advance.
- R4: A status bit stays set until software writes 1 to it at address 0. Writing 0 to a bit leaves it unchanged. If an event pulse and a clearing write reach the same bit in the same cycle, the bit stays set.
- R5: For an immediate source (bits 2, 3 and 4), `irq` is high from the first clock edge at which both its status bit and its enable bit are set.
- R6: A deferred source (bits 0, 1 and 5) does not raise `irq` before a clock edge with `thresh_tick` high at which its status bit and its enable bit were already set. From that edge on, it raises `irq`.
- R7: `irq` stays high while any immediate source, or any latched deferred source, remains set and enabled. Clearing the last such status bit drops `irq` at that write's clock edge.
- R8: Writing 0 to an enable bit removes that source from `irq` at the same clock edge. The status bit does not change.
- R9: A write to any address other than 0 or 1 changes nothing, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 6 | Event pulses, one bit per source |
| thresh_tick | input | 1 | Marks an interrupt threshold boundary |
| irq | output | 1 | Interrupt request |

## Verification
Every stored result becomes visible one clock edge after the stimulus that causes it. This covers status set and clear, enable writes, latching on the threshold tick, and the resulting `irq` level, because `irq` is decoded from registered state only. Read data is combinational, so it reflects the current address in the same cycle. The bench drives inputs on the falling edge and samples `irq` on the next falling edge, after exactly one rising edge. It reads the registers between edges, with the write strobe low. Its reference model advances once per rising edge. The deferred checks pulse an event, confirm `irq` stays low for several cycles without a tick, and then confirm `irq` rises one edge after the tick.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int SRC_N = 6;
  // deferred sources: transfer complete (0), USB error (1), async advance (5)
  localparam logic [SRC_N-1:0] DEFER_MASK = 6'b100011;

  function automatic logic is_deferred(input int idx);
    return DEFER_MASK[idx];
  endfunction

  // next status: event sets, write-1 clears, event wins
  function automatic logic [SRC_N-1:0] status_step(
    input logic [SRC_N-1:0] cur,
    input logic [SRC_N-1:0] evt,
    input logic [SRC_N-1:0] clr);
    return (cur & ~clr) | evt;
  endfunction
endpackage

// File: rtl/hc_irq_status.sv
module hc_irq_status #(
  parameter int SRC_N = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt,
  input  logic [SRC_N-1:0] clr_vec,
  output logic [SRC_N-1:0] status_q,
  output logic [SRC_N-1:0] status_d
);
  import hc_irq_pkg::*;

  assign status_d = status_step(status_q, evt, clr_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  // R3: every pulsed bit is set one edge later
  assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

  // R4: a bit only falls after a clearing write to it
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_q) |=> (($past(status_q) & ~status_q & ~$past(clr_vec)) == '0));
endmodule

// File: rtl/hc_irq_enable.sv
module hc_irq_enable #(
  parameter int SRC_N = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SRC_N-1:0] wval,
  output logic [SRC_N-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wval;
  end

  // R2: enable register is stable unless written
  assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/hc_irq_combine.sv
module hc_irq_combine #(
  parameter int SRC_N = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SRC_N-1:0] status_q,
  input  logic [SRC_N-1:0] status_d,
  input  logic [SRC_N-1:0] en_q,
  output logic [SRC_N-1:0] latch_q,
  output logic             irq
);
  import hc_irq_pkg::*;

  logic [SRC_N-1:0] defer_m;
  logic [SRC_N-1:0] imm_active;
  logic [SRC_N-1:0] def_active;
  logic [SRC_N-1:0] latch_d;

  for (genvar i = 0; i < SRC_N; i++) begin : g_cls
    assign defer_m[i] = is_deferred(i);
  end

  assign latch_d    = (latch_q | (tick ? (status_q & en_q & defer_m) : '0)) & status_d;
  assign imm_active = status_q & en_q & ~defer_m;
  assign def_active = latch_q & status_q & en_q;
  assign irq        = (|imm_active) | (|def_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  // R6: a deferred source enters the latch only on a tick edge
  assert_defer_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((latch_q & ~$past(latch_q)) == '0));

  // R6: nothing but deferred sources is ever latched
  assert_latch_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q & ~defer_m) == '0);
endmodule

// File: rtl/hc_irq_aggregator.sv
module hc_irq_aggregator #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int STATUS_ADDR = 0,
  parameter int ENABLE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [hc_irq_pkg::SRC_N-1:0] evt_pulse,
  input  logic              thresh_tick,
  output logic              irq
);
  localparam int SRC_N = hc_irq_pkg::SRC_N;
  localparam int PAD_W = DATA_W - SRC_N;

  logic             sel_status;
  logic             sel_enable;
  logic [SRC_N-1:0] clr_vec;
  logic [SRC_N-1:0] status_q;
  logic [SRC_N-1:0] status_d;
  logic [SRC_N-1:0] en_q;
  logic [SRC_N-1:0] latch_q;

  assign sel_status = (reg_addr == ADDR_W'(STATUS_ADDR));
  assign sel_enable = (reg_addr == ADDR_W'(ENABLE_ADDR));
  assign clr_vec    = (reg_wr && sel_status) ? reg_wdata[SRC_N-1:0] : '0;

  hc_irq_status #(.SRC_N(SRC_N)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr_vec(clr_vec),
    .status_q(status_q), .status_d(status_d));

  hc_irq_enable #(.SRC_N(SRC_N)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel_enable),
    .wval(reg_wdata[SRC_N-1:0]), .en_q(en_q));

  hc_irq_combine #(.SRC_N(SRC_N)) u_combine (
    .clk(clk), .rst_n(rst_n), .tick(thresh_tick), .status_q(status_q),
    .status_d(status_d), .en_q(en_q), .latch_q(latch_q), .irq(irq));

  always_comb begin
    if (sel_status)      reg_rdata = {{PAD_W{1'b0}}, status_q};
    else if (sel_enable) reg_rdata = {{PAD_W{1'b0}}, en_q};
    else                 reg_rdata = '0;
  end

  // R7: irq needs at least one set and enabled source
  assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(status_q & en_q)));

  // R5: an enabled immediate source drives irq
  assert_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & en_q & ~hc_irq_pkg::DEFER_MASK)) |-> irq);

  // R8: an enable write never touches status unless an event or clear also arrives
  assert_enable_no_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel_enable && evt_pulse == '0) |=> (status_q == $past(status_q)));
endmodule

// File: tb/tb_hc_irq_aggregator.sv
module tb_hc_irq_aggregator;
  localparam logic [5:0] DEF = 6'b100011;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [5:0]  evt_pulse = 0;
  logic        thresh_tick = 0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  logic [5:0] m_st = 0, m_en = 0, m_lat = 0;

  always #5 clk = ~clk;

  hc_irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .thresh_tick(thresh_tick), .irq(irq));

  function automatic logic exp_irq(input logic [5:0] st, en, lat);
    logic [5:0] live;
    live = st & en;
    return ((live & ~DEF) != 0) || ((live & lat) != 0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, advance model, sample at next negedge
  task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] d,
                      input logic [5:0] ev, input logic tk);
    logic [5:0] clr, st_n;
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt_pulse = ev; thresh_tick = tk;
    clr  = (wr && a == 2'd0) ? d[5:0] : 6'd0;
    st_n = (m_st & ~clr) | ev;
    m_lat = (m_lat | (tk ? (m_st & m_en & DEF) : 6'd0)) & st_n;
    if (wr && a == 2'd1) m_en = d[5:0];
    m_st = st_n;
    @(negedge clk);
    reg_wr = 0; evt_pulse = 0; thresh_tick = 0;
  endtask

  task automatic idle(); step(0, 2'd0, 0, 0, 0); endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 irq", {31'd0, irq}, 0);
    rd("R1 status", 2'd0, 0);
    rd("R1 enable", 2'd1, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: reserved enable bits read 0
    step(1, 2'd1, 32'hFFFF_FFFF, 0, 0);
    rd("R2 enable", 2'd1, 32'h3F);
    step(1, 2'd1, 32'hA5A5_A500, 0, 0);
    rd("R2 clear", 2'd1, 0);

    // R9: unmapped address ignored
    step(1, 2'd2, 32'hFFFF_FFFF, 0, 0);
    step(1, 2'd3, 32'hFFFF_FFFF, 0, 0);
    rd("R9 read2", 2'd2, 0);
    rd("R9 enable", 2'd1, 0);

    // R3: events set bits; R4: sticky and clear
    step(0, 2'd0, 0, 6'b010101, 0);
    rd("R3 status", 2'd0, 32'h15);
    idle(); idle();
    rd("R4 sticky", 2'd0, 32'h15);
    step(1, 2'd0, 32'h0000_0000, 0, 0);
    rd("R4 write0", 2'd0, 32'h15);
    step(1, 2'd0, 32'h0000_0005, 6'b000001, 0);
    rd("R4 event wins", 2'd0, 32'h11);
    step(1, 2'd0, 32'hFFFF_FFFF, 0, 0);
    rd("R4 clear all", 2'd0, 0);

    // R5: immediate source
    step(1, 2'd1, 32'h3F, 0, 0);
    step(0, 2'd0, 0, 6'b001000, 0);
    check("R5 immediate", {31'd0, irq}, 1);
    // R8: disable removes, status kept
    step(1, 2'd1, 32'h37, 0, 0);
    check("R8 irq off", {31'd0, irq}, 0);
    rd("R8 status kept", 2'd0, 32'h08);
    step(1, 2'd1, 32'h3F, 0, 0);
    check("R8 re-enable", {31'd0, irq}, 1);
    step(1, 2'd0, 32'h08, 0, 0);
    check("R7 drop on clear", {31'd0, irq}, 0);

    // R6: deferred source waits for tick
    step(0, 2'd0, 0, 6'b100000, 0);
    for (int k = 0; k < 5; k++) begin
      check("R6 no tick", {31'd0, irq}, 0);
      idle();
    end
    step(0, 2'd0, 0, 0, 1);
    check("R6 after tick", {31'd0, irq}, 1);
    idle(); idle();
    check("R7 held", {31'd0, irq}, 1);
    step(1, 2'd0, 32'h20, 0, 0);
    check("R7 cleared", {31'd0, irq}, 0);
    // R6: event on the tick cycle is not latched
    step(0, 2'd0, 0, 6'b000010, 1);
    check("R6 same-cycle", {31'd0, irq}, 0);
    step(0, 2'd0, 0, 0, 1);
    check("R6 next tick", {31'd0, irq}, 1);
    step(1, 2'd0, 32'h3F, 0, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      logic [5:0] ev;
      r  = $urandom;
      ev = ((r[3:0] == 0) ? 6'($urandom) : 6'd0);
      if (r[7:4] < 2)      step(1, 2'd0, $urandom, ev, r[10:8] == 0);
      else if (r[7:4] < 3) step(1, 2'd1, $urandom, ev, r[10:8] == 0);
      else if (r[7:4] < 4) step(1, r[12] ? 2'd2 : 2'd3, $urandom, ev, r[10:8] == 0);
      else                 step(0, 2'd0, 0, ev, r[10:8] == 0);
      check("R7 random irq", {31'd0, irq}, {31'd0, exp_irq(m_st, m_en, m_lat)});
      if (r[15:13] == 0) begin
        rd("R3 random status", 2'd0, {26'd0, m_st});
        rd("R2 random enable", 2'd1, {26'd0, m_en});
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule